// File: doc/BRIEF.md
# Two-Wide Register Renamer with Branch Checkpoint

This block translates the architectural register numbers of up to two decoded instructions per cycle into physical register tags. A map table gives the newest physical tag for every architectural register. A free bitmap tracks the physical registers that are not holding any live value. Each instruction that writes a register is given a fresh tag, and its destination entry in the map is repointed to that tag. The tag it displaces is handed out on the rename port so that the commit logic can return it later, once the overwriting instruction retires.

When a branch is renamed, the block copies the map table and starts recording which tags are handed out after that point. Only one branch may be outstanding at a time. If the branch resolves as mispredicted, the map table is reloaded from the copy and every tag handed out since the branch goes back into the free bitmap. A correct resolve simply drops the copy. The two lanes of a group are ordered: lane 0 is older. Lane 1 sees the destination written by lane 0 in the same group.

Top module: `rn_rename`

## Requirements
- R1: After reset, architectural register i maps to physical tag i (for i in 0..31), and tags 32..63 are free.
- R2: Each source output gives the physical tag currently mapped to that source register, as updated by all earlier accepted groups.
- R3: A lane that writes a register is given the lowest-numbered free tag; when both lanes write, lane 1 gets the second-lowest. The lane's old-tag output is the previous mapping of its destination, and the map entry takes the new tag at the clock edge.
- R4: Inside one group, a lane 1 source or destination that equals the lane 0 destination uses lane 0's new tag in place of the table value. When both lanes write the same register, lane 1's tag is the one left in the map.
- R5: `rn_stall` is high, and the whole group leaves the map and free bitmap untouched, when fewer tags are free than the group needs.
- R6: A commit with a displaced tag returns that tag to the free bitmap at the clock edge, so it can be handed out again from the next cycle on.
- R7: Accepting a branch (a valid lane with its branch flag set and its write flag clear) records a checkpoint. A branch offered while a checkpoint is held, or two branches in one group, raise `rn_stall`. A branch in lane 1 puts lane 0's mapping into the checkpoint. A branch in lane 0 leaves lane 1's mapping out of it.
- R8: A mispredict while a checkpoint is held reloads the map table from the checkpoint and returns to the free bitmap every tag handed out after the branch.
- R9: A correct resolve releases the checkpoint, keeps all current mappings, and lets the next branch be accepted.
- R10: In a cycle with a mispredict, any offered group is stalled and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i0_valid | input | 1 | Lane 0 holds an instruction |
| i0_wr | input | 1 | Lane 0 writes a destination register |
| i0_branch | input | 1 | Lane 0 is a branch |
| i0_dst | input | 5 | Lane 0 destination register |
| i0_srca | input | 5 | Lane 0 first source register |
| i0_srcb | input | 5 | Lane 0 second source register |
| i1_valid | input | 1 | Lane 1 holds an instruction |
| i1_wr | input | 1 | Lane 1 writes a destination register |
| i1_branch | input | 1 | Lane 1 is a branch |
| i1_dst | input | 5 | Lane 1 destination register |
| i1_srca | input | 5 | Lane 1 first source register |
| i1_srcb | input | 5 | Lane 1 second source register |
| rn_stall | output | 1 | Group not accepted this cycle |
| o0_psrca | output | 6 | Lane 0 first source tag |
| o0_psrcb | output | 6 | Lane 0 second source tag |
| o0_pdst | output | 6 | Lane 0 new destination tag |
| o0_pold | output | 6 | Lane 0 displaced tag |
| o1_psrca | output | 6 | Lane 1 first source tag |
| o1_psrcb | output | 6 | Lane 1 second source tag |
| o1_pdst | output | 6 | Lane 1 new destination tag |
| o1_pold | output | 6 | Lane 1 displaced tag |
| cm_valid | input | 1 | Commit returns a tag this cycle |
| cm_tag | input | 6 | Displaced tag to free |
| rs_valid | input | 1 | Outstanding branch resolves |
| rs_mispredict | input | 1 | Resolved branch was mispredicted |

## Verification
The assertions rely on the following rules about the inputs. A committed tag is one that was handed out as a displaced tag and is not already free. Resolves arrive only while a checkpoint is held. A branch lane never sets its write flag. Commits never name a tag that was handed out after the outstanding branch. The stimulus follows these rules. It commits only tags it saw on an old-tag output from an older group, it resolves only after a branch was accepted, and it drives every branch lane with its write flag low.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int ARCH_REGS = 32;
  localparam int PHYS_REGS = 64;
  localparam int AREG_W    = $clog2(ARCH_REGS);
  localparam int TAG_W     = $clog2(PHYS_REGS);
  localparam int CNT_W     = TAG_W + 1;
  localparam int RD_PORTS  = 6;

  typedef logic [TAG_W-1:0]     ptag_t;
  typedef logic [AREG_W-1:0]    areg_t;
  typedef logic [PHYS_REGS-1:0] pmask_t;

  // lowest set bit of a mask, 0 when empty
  function automatic ptag_t lowest_set(input pmask_t m);
    ptag_t r;
    r = '0;
    for (int i = PHYS_REGS - 1; i >= 0; i--)
      if (m[i]) r = ptag_t'(i);
    return r;
  endfunction

  function automatic pmask_t tag_bit(input ptag_t t);
    return pmask_t'(1) << t;
  endfunction

  function automatic pmask_t initial_free();
    pmask_t m;
    for (int i = 0; i < PHYS_REGS; i++) m[i] = (i >= ARCH_REGS);
    return m;
  endfunction
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist
  import rn_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req0,
  input  logic  alloc0_en,
  input  logic  alloc1_en,
  input  logic  cmt_en,
  input  ptag_t cmt_tag,
  input  logic  ckpt_start,
  input  logic  ckpt_in_lane1,
  input  logic  ckpt_active,
  input  logic  restore,
  output ptag_t pick0,
  output ptag_t pick1,
  output logic [CNT_W-1:0] free_cnt
);
  pmask_t free_q, since_q, take_mask, free_d;
  ptag_t  first_t, second_t;

  assign first_t  = lowest_set(free_q);
  assign second_t = lowest_set(free_q & ~tag_bit(first_t));
  assign pick0    = first_t;
  assign pick1    = req0 ? second_t : first_t;
  assign free_cnt = CNT_W'($countones(free_q));

  assign take_mask = (alloc0_en ? tag_bit(pick0) : '0) |
                     (alloc1_en ? tag_bit(pick1) : '0);
  assign free_d    = (free_q & ~take_mask) |
                     (cmt_en  ? tag_bit(cmt_tag) : '0) |
                     (restore ? since_q : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q  <= initial_free();
      since_q <= '0;
    end else begin
      free_q <= free_d;
      if (restore)          since_q <= '0;
      else if (ckpt_start)  since_q <= ckpt_in_lane1 ? '0 : take_mask;
      else if (ckpt_active) since_q <= since_q | take_mask;
    end
  end

  AST_ALLOC_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc0_en |-> free_q[pick0]); // R3
  AST_ALLOC_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc0_en && alloc1_en) |-> (pick0 != pick1)); // R3
  AST_TAKEN_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc1_en |=> !free_q[$past(pick1)]); // R3
  AST_CMT_NOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_en |-> !free_q[cmt_tag]); // R6
  AST_RESTORE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> ((free_q & $past(since_q)) == $past(since_q))); // R8
endmodule

// File: rtl/rn_maptable.sv
module rn_maptable
  import rn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  areg_t [RD_PORTS-1:0] rd_a,
  output ptag_t [RD_PORTS-1:0] rd_t,
  input  logic  w0_en,
  input  areg_t w0_a,
  input  ptag_t w0_t,
  input  logic  w1_en,
  input  areg_t w1_a,
  input  ptag_t w1_t,
  input  logic  snap_en,
  input  logic  snap_after_w0,
  input  logic  restore
);
  ptag_t [ARCH_REGS-1:0] map_q, snap_q, snap_d;

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd_t[p] = map_q[rd_a[p]];
  end

  for (genvar i = 0; i < ARCH_REGS; i++) begin : g_snap
    assign snap_d[i] = (snap_after_w0 && w0_en && w0_a == areg_t'(i)) ? w0_t : map_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) begin
        map_q[i]  <= ptag_t'(i);
        snap_q[i] <= ptag_t'(i);
      end
    end else begin
      if (restore) map_q <= snap_q;
      else begin
        if (w0_en) map_q[w0_a] <= w0_t;
        if (w1_en) map_q[w1_a] <= w1_t;
      end
      if (snap_en) snap_q <= snap_d;
    end
  end

  AST_MAP_RELOADED: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> (map_q == $past(snap_q))); // R8
endmodule

// File: rtl/rn_rename.sv
module rn_rename
  import rn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i0_valid,
  input  logic              i0_wr,
  input  logic              i0_branch,
  input  logic [AREG_W-1:0] i0_dst,
  input  logic [AREG_W-1:0] i0_srca,
  input  logic [AREG_W-1:0] i0_srcb,
  input  logic              i1_valid,
  input  logic              i1_wr,
  input  logic              i1_branch,
  input  logic [AREG_W-1:0] i1_dst,
  input  logic [AREG_W-1:0] i1_srca,
  input  logic [AREG_W-1:0] i1_srcb,
  output logic              rn_stall,
  output logic [TAG_W-1:0]  o0_psrca,
  output logic [TAG_W-1:0]  o0_psrcb,
  output logic [TAG_W-1:0]  o0_pdst,
  output logic [TAG_W-1:0]  o0_pold,
  output logic [TAG_W-1:0]  o1_psrca,
  output logic [TAG_W-1:0]  o1_psrcb,
  output logic [TAG_W-1:0]  o1_pdst,
  output logic [TAG_W-1:0]  o1_pold,
  input  logic              cm_valid,
  input  logic [TAG_W-1:0]  cm_tag,
  input  logic              rs_valid,
  input  logic              rs_mispredict
);
  logic req0, req1, br0, br1, any_v, any_br, kill, go;
  logic ckpt_valid, restore, w0_en, w1_en;
  logic [CNT_W-1:0] need, free_cnt;
  ptag_t pick0, pick1;
  areg_t [RD_PORTS-1:0] rd_a;
  ptag_t [RD_PORTS-1:0] rd_t;

  assign req0   = i0_valid & i0_wr;
  assign req1   = i1_valid & i1_wr;
  assign br0    = i0_valid & i0_branch;
  assign br1    = i1_valid & i1_branch;
  assign any_v  = i0_valid | i1_valid;
  assign any_br = br0 | br1;
  assign kill   = rs_valid & rs_mispredict;
  assign need   = CNT_W'(req0) + CNT_W'(req1);

  assign rn_stall = any_v & (kill | (need > free_cnt) |
                             (any_br & ckpt_valid) | (br0 & br1));
  assign go       = any_v & ~rn_stall;
  assign w0_en    = go & req0;
  assign w1_en    = go & req1;
  assign restore  = kill & ckpt_valid;

  always_ff @(posedge clk) begin
    if (!rst_n)            ckpt_valid <= 1'b0;
    else if (go && any_br) ckpt_valid <= 1'b1;
    else if (rs_valid)     ckpt_valid <= 1'b0;
  end

  assign rd_a = {i1_dst, i0_dst, i1_srcb, i1_srca, i0_srcb, i0_srca};

  rn_maptable u_map (
    .clk, .rst_n, .rd_a, .rd_t,
    .w0_en, .w0_a(i0_dst), .w0_t(pick0),
    .w1_en, .w1_a(i1_dst), .w1_t(pick1),
    .snap_en(go & any_br), .snap_after_w0(br1), .restore
  );

  rn_freelist u_free (
    .clk, .rst_n, .req0,
    .alloc0_en(w0_en), .alloc1_en(w1_en),
    .cmt_en(cm_valid), .cmt_tag(cm_tag),
    .ckpt_start(go & any_br), .ckpt_in_lane1(br1),
    .ckpt_active(ckpt_valid), .restore,
    .pick0, .pick1, .free_cnt
  );

  // lane 1 sees lane 0's new destination inside the group
  assign o0_psrca = rd_t[0];
  assign o0_psrcb = rd_t[1];
  assign o0_pdst  = pick0;
  assign o0_pold  = rd_t[4];
  assign o1_psrca = (req0 && i1_srca == i0_dst) ? pick0 : rd_t[2];
  assign o1_psrcb = (req0 && i1_srcb == i0_dst) ? pick0 : rd_t[3];
  assign o1_pdst  = pick1;
  assign o1_pold  = (req0 && i1_dst == i0_dst) ? pick0 : rd_t[5];

  AST_ONE_CHECKPOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (go && any_br) |-> !ckpt_valid); // R7
  AST_KILL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> !(w0_en || w1_en)); // R10
endmodule

// File: tb/rn_rename_tb.sv
module rn_rename_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v0, w0, b0, v1, w1, b1, cmv, rsv, rsm;
  logic [4:0] d0, a0, c0, d1, a1, c1;
  logic [5:0] cmt;
  logic stall;
  logic [5:0] p0a, p0b, p0d, p0o, p1a, p1b, p1d, p1o;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  rn_rename u_dut (
    .clk, .rst_n,
    .i0_valid(v0), .i0_wr(w0), .i0_branch(b0), .i0_dst(d0), .i0_srca(a0), .i0_srcb(c0),
    .i1_valid(v1), .i1_wr(w1), .i1_branch(b1), .i1_dst(d1), .i1_srca(a1), .i1_srcb(c1),
    .rn_stall(stall),
    .o0_psrca(p0a), .o0_psrcb(p0b), .o0_pdst(p0d), .o0_pold(p0o),
    .o1_psrca(p1a), .o1_psrcb(p1b), .o1_pdst(p1d), .o1_pold(p1o),
    .cm_valid(cmv), .cm_tag(cmt), .rs_valid(rsv), .rs_mispredict(rsm)
  );

  typedef struct packed {
    logic v0, h0; logic [4:0] d0, a0, b0;
    logic v1, h1; logic [4:0] d1, a1, b1;
    logic [5:0] pd0, po0, s0a, s0b, pd1, po1, s1a, s1b;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b1, 1'b1, 5'd1, 5'd2, 5'd3, 1'b1, 1'b1, 5'd4, 5'd1, 5'd5,
      6'd32, 6'd1, 6'd2, 6'd3, 6'd33, 6'd4, 6'd32, 6'd5},
    '{1'b1, 1'b1, 5'd1, 5'd1, 5'd4, 1'b1, 1'b1, 5'd1, 5'd1, 5'd0,
      6'd34, 6'd32, 6'd32, 6'd33, 6'd35, 6'd34, 6'd34, 6'd0},
    '{1'b1, 1'b0, 5'd0, 5'd1, 5'd4, 1'b1, 1'b1, 5'd7, 5'd7, 5'd1,
      6'd0, 6'd0, 6'd35, 6'd33, 6'd36, 6'd7, 6'd7, 6'd35},
    '{1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd2, 5'd4, 5'd7,
      6'd0, 6'd0, 6'd0, 6'd0, 6'd37, 6'd2, 6'd33, 6'd36}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    v0 = 0; w0 = 0; b0 = 0; d0 = 0; a0 = 0; c0 = 0;
    v1 = 0; w1 = 0; b1 = 0; d1 = 0; a1 = 0; c1 = 0;
    cmv = 0; cmt = 0; rsv = 0; rsm = 0;
  endtask

  task automatic lane0(input logic wr, input logic br, input int d, input int a, input int b);
    v0 = 1; w0 = wr; b0 = br; d0 = 5'(d); a0 = 5'(a); c0 = 5'(b);
  endtask

  task automatic lane1(input logic wr, input logic br, input int d, input int a, input int b);
    v1 = 1; w1 = wr; b1 = br; d1 = 5'(d); a1 = 5'(a); c1 = 5'(b);
  endtask

  task automatic next();
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();

    // R1: reset mapping and free order
    lane0(1, 0, 5, 0, 31); lane1(1, 0, 6, 17, 6);
    #2;
    chk("R1 src r0", int'(p0a), 0);
    chk("R1 src r31", int'(p0b), 31);
    chk("R1 first free", int'(p0d), 32);
    chk("R1 old tag", int'(p0o), 5);
    chk("R1 second free", int'(p1d), 33);
    chk("R1 src r17", int'(p1a), 17);
    idle();
    @(negedge clk);

    // R2 R3 R4: vector table
    foreach (VECS[k]) begin
      vec_t e;
      e = VECS[k];
      v0 = e.v0; w0 = e.h0; d0 = e.d0; a0 = e.a0; c0 = e.b0;
      v1 = e.v1; w1 = e.h1; d1 = e.d1; a1 = e.a1; c1 = e.b1;
      #2;
      chk("R5 no stall in table", int'(stall), 0);
      if (e.v0) begin
        chk("R2 lane0 srca", int'(p0a), int'(e.s0a));
        chk("R2 lane0 srcb", int'(p0b), int'(e.s0b));
        if (e.h0) begin
          chk("R3 lane0 pdst", int'(p0d), int'(e.pd0));
          chk("R3 lane0 pold", int'(p0o), int'(e.po0));
        end
      end
      if (e.v1) begin
        chk("R4 lane1 srca", int'(p1a), int'(e.s1a));
        chk("R4 lane1 srcb", int'(p1b), int'(e.s1b));
        chk("R3 lane1 pdst", int'(p1d), int'(e.pd1));
        chk("R4 lane1 pold", int'(p1o), int'(e.po1));
      end
      next();
    end

    // R6: commit tag 1, then it is handed out again
    cmv = 1; cmt = 6'd1;
    next();
    lane0(1, 0, 9, 1, 2);
    #2;
    chk("R6 freed tag reused", int'(p0d), 1);
    chk("R2 r1 newest", int'(p0a), 35);
    next();

    // R5: exhaust the free list
    do_reset();
    for (int g = 0; g < 16; g++) begin
      lane0(1, 0, 10, 0, 0); lane1(1, 0, 11, 0, 0);
      #2;
      chk("R3 sweep lane0", int'(p0d), 32 + 2 * g);
      chk("R3 sweep lane1", int'(p1d), 33 + 2 * g);
      next();
    end
    lane0(1, 0, 10, 10, 11);
    #2;
    chk("R5 stall on empty", int'(stall), 1);
    chk("R2 r10 after sweep", int'(p0a), 62);
    next();
    lane0(0, 0, 0, 10, 11);
    #2;
    chk("R5 stalled group wrote nothing r10", int'(p0a), 62);
    chk("R5 stalled group wrote nothing r11", int'(p0b), 63);
    chk("R5 no dest no stall", int'(stall), 0);
    next();
    cmv = 1; cmt = 6'd10;
    next();
    lane0(1, 0, 12, 0, 0); lane1(1, 0, 13, 0, 0);
    #2;
    chk("R5 two needed one free", int'(stall), 1);
    idle();
    lane0(1, 0, 12, 0, 0);
    #2;
    chk("R5 one needed one free", int'(stall), 0);
    chk("R6 committed tag given", int'(p0d), 10);
    next();

    // R7 R8 R9 R10: checkpoint
    do_reset();
    lane0(0, 1, 0, 0, 0); lane1(1, 0, 3, 3, 3);
    #2;
    chk("R7 branch accepted", int'(stall), 0);
    chk("R3 lane1 lowest when lane0 no dst", int'(p1d), 32);
    next();
    lane0(1, 0, 5, 0, 0); lane1(1, 0, 3, 3, 0);
    #2;
    chk("R3 lane0 after branch", int'(p0d), 33);
    chk("R3 lane1 after branch", int'(p1d), 34);
    chk("R2 r3 newest", int'(p1a), 32);
    next();
    lane0(0, 1, 0, 0, 0);
    #2;
    chk("R7 second branch stalls", int'(stall), 1);
    next();
    rsv = 1; rsm = 1; lane0(1, 0, 6, 0, 0);
    #2;
    chk("R10 stall on mispredict", int'(stall), 1);
    next();
    lane0(0, 0, 0, 3, 5); lane1(1, 0, 6, 6, 0);
    #2;
    chk("R8 r3 restored", int'(p0a), 3);
    chk("R8 r5 restored", int'(p0b), 5);
    chk("R10 r6 untouched", int'(p1a), 6);
    chk("R10 r6 old tag", int'(p1o), 6);
    chk("R8 tag 32 back", int'(p1d), 32);
    next();
    lane0(1, 0, 8, 0, 0); lane1(0, 1, 0, 0, 0);
    #2;
    chk("R7 lane1 branch accepted", int'(stall), 0);
    chk("R8 tag 33 back", int'(p0d), 33);
    next();
    lane0(1, 0, 8, 8, 0);
    #2;
    chk("R2 r8 newest", int'(p0a), 33);
    chk("R3 after lane1 branch", int'(p0d), 34);
    next();
    rsv = 1; rsm = 1;
    next();
    lane0(1, 0, 9, 8, 6); lane1(0, 1, 0, 0, 0);
    #2;
    chk("R7 lane0 kept in checkpoint", int'(p0a), 33);
    chk("R8 r6 kept", int'(p0b), 32);
    chk("R8 tag 34 back", int'(p0d), 34);
    chk("R7 branch after restore", int'(stall), 0);
    next();
    rsv = 1; rsm = 0;
    next();
    lane0(0, 1, 0, 9, 8);
    #2;
    chk("R9 branch after correct resolve", int'(stall), 0);
    chk("R9 r9 mapping kept", int'(p0a), 34);
    chk("R9 r8 mapping kept", int'(p0b), 33);
    next();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule